// File: doc/BRIEF.md
# Prefilling Frame Buffer Controller

This block manages a large byte buffer placed between a network-fed input stream and a modulator. Data arrives on the write side in fixed-size blocks. Each block is either taken whole or refused whole, based on the free space left when its first byte arrives. On the read side the modulator asks for one byte per cycle. In free-running mode no byte is handed out until the buffer has filled to three quarters of its capacity. Output then continues until the buffer drains empty, and the block goes back to waiting for the prefill level. This absorbs jitter in network delivery. In synchronised mode the fill level is not used, and any stored byte can be read.

The buffer is modelled as a generic memory split into two equal banks. A percentage of fullness is reported all the time. A long-interval watchdog, built from a tick prescaler and a tick counter, raises a one-cycle flush request when no byte has left the block for the whole timeout. The same pulse empties the buffer internally so the stream can resynchronise. When the buffer is switched off, input bytes pass straight to the output.

The read-side state machine has three states. `RD_BYPASS` is used while disabled. `RD_PREFILL` waits for the start level. `RD_STREAM` serves reads. Its transitions are:
- enable: `RD_BYPASS` to `RD_PREFILL`
- level reached: `RD_PREFILL` to `RD_STREAM`
- drained: `RD_STREAM` to `RD_PREFILL`
- watchdog flush: any enabled state to `RD_PREFILL`
- disable: any state to `RD_BYPASS`

The write-side state machine has three states. `WR_IDLE` waits for a block start. `WR_TAKE` stores the rest of an admitted block. `WR_DROP` discards the rest of a refused block. Its transitions are:
- admit: `WR_IDLE` to `WR_TAKE`
- refuse: `WR_IDLE` to `WR_DROP`
- block end: `WR_TAKE` or `WR_DROP` back to `WR_IDLE`
- flush or disable: any state to `WR_IDLE`

Top module: `fbuf_ctrl`

## Requirements
- R1: After reset, `rd_valid`, `overflow` and `flush_req` are 0 and `fill_pct` is 0.
- R2: With `buf_en`=1 and `sync_mode`=0, no byte is output while the read machine waits in prefill. Prefill ends only once the stored byte count reaches CAP*3/4 (192 of 256 by default).
- R3: Once streaming, reads are served until the buffer is empty. The block then returns to prefill and again outputs nothing until the start level is reached.
- R4: Bytes leave in the order they were stored. `rd_valid` is high, with the byte on `rd_data`, in the cycle after the cycle in which a served `rd_req` was sampled.
- R5: A block is marked by `wr_first`=1 on its first byte and spans BLK bytes (16 by default). It is stored only if at least BLK bytes are free when that first byte arrives. Otherwise all of its bytes are dropped, stored data is left intact, and `overflow` is set and stays set.
- R6: A `wr_en` byte without `wr_first` while no block is in progress is ignored.
- R7: `fill_pct` equals floor(stored_bytes*100/CAP).
- R8: With `sync_mode`=1 there is no prefill level. Reads are served whenever at least one byte is stored.
- R9: With `buf_en`=0, `rd_valid` and `rd_data` repeat `wr_en` and `wr_data` one cycle later, and nothing is stored (`fill_pct` stays 0).
- R10: With `buf_en`=1, if `rd_valid` stays low for TICK_DIV*WD_TICKS cycles (1024 by default), `flush_req` pulses for one cycle. The buffer is then emptied, `overflow` is cleared, and the block re-enters prefill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_en | input | 1 | 1 = use the buffer, 0 = pass-through |
| sync_mode | input | 1 | 1 = no prefill level before output |
| wr_en | input | 1 | Input byte present |
| wr_first | input | 1 | Input byte is the first of a block |
| wr_data | input | 8 | Input byte |
| rd_req | input | 1 | Modulator asks for a byte |
| rd_valid | output | 1 | Output byte present |
| rd_data | output | 8 | Output byte |
| fill_pct | output | 7 | Buffer fullness, percent |
| overflow | output | 1 | Sticky: a block was refused |
| flush_req | output | 1 | One-cycle watchdog reset request |

## Verification
The start-up patterns are a fill stopping just below the three-quarter level and then one block reaching it. Together they show whether the gate opens on the right count. A full drain followed by a single new block shows whether the gate re-arms after emptying. Filling to exactly BLK free bytes and then sending one more block separates admission at the boundary from refusal, and reading back the whole buffer shows that the refused bytes overwrote nothing. Stray writes with no block start, synchronised reads of a single block, pass-through traffic and a silent stretch long enough to trip the watchdog each exercise one distinct mode.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
    typedef enum logic [1:0] {
        RD_BYPASS  = 2'd0,
        RD_PREFILL = 2'd1,
        RD_STREAM  = 2'd2
    } rd_state_t;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_TAKE = 2'd1,
        WR_DROP = 2'd2
    } wr_state_t;
endpackage

// File: rtl/fbuf_mem.sv
// Generic two-bank byte store; one write and one registered read per cycle.
module fbuf_mem #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic sel_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DW-1:0] cells [HALF];
        logic [DW-1:0] q_r;
        always_ff @(posedge clk) begin
            if (we && (waddr[AW-1] == 1'(b))) begin
                cells[waddr[AW-2:0]] <= wdata;
            end
            q_r <= cells[raddr[AW-2:0]];
        end
    end

    always_ff @(posedge clk) begin
        sel_q <= raddr[AW-1];
    end

    assign rdata = sel_q ? g_bank[1].q_r : g_bank[0].q_r;
endmodule

// File: rtl/fbuf_wr_fsm.sv
// Block admission: whole block taken or whole block dropped (BLK >= 2).
module fbuf_wr_fsm
    import fbuf_pkg::*;
#(
    parameter int BLK   = 16,
    parameter int CNT_W = 9,
    localparam int BC_W = $clog2(BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic             wr_first,
    input  logic [CNT_W-1:0] free,
    output logic             wr_do,
    output logic             ovf_set
);
    wr_state_t st, st_nxt;
    logic [BC_W-1:0] bc;
    logic last_byte;

    assign last_byte = (bc == BC_W'(BLK - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st <= WR_IDLE;
            bc <= '0;
        end else begin
            st <= st_nxt;
            if (st == WR_IDLE) begin
                bc <= (wr_en && wr_first) ? BC_W'(1) : '0;
            end else if (wr_en) begin
                bc <= last_byte ? '0 : bc + BC_W'(1);
            end
        end
    end

    always_comb begin
        st_nxt  = st;
        wr_do   = 1'b0;
        ovf_set = 1'b0;
        unique case (st)
            WR_IDLE: begin
                if (wr_en && wr_first) begin
                    if (free >= CNT_W'(BLK)) begin
                        wr_do  = 1'b1;
                        st_nxt = WR_TAKE;
                    end else begin
                        ovf_set = 1'b1;
                        st_nxt  = WR_DROP;
                    end
                end
            end
            WR_TAKE: begin
                if (wr_en) begin
                    wr_do = 1'b1;
                    if (last_byte) st_nxt = WR_IDLE;
                end
            end
            WR_DROP: begin
                if (wr_en && last_byte) st_nxt = WR_IDLE;
            end
            default: st_nxt = WR_IDLE;
        endcase
    end
endmodule

// File: rtl/fbuf_rd_fsm.sv
// Read gating: prefill level before streaming, stream until drained.
module fbuf_rd_fsm
    import fbuf_pkg::*;
#(
    parameter int CAP       = 256,
    parameter int CNT_W     = 9,
    localparam int FILL_LVL = (CAP * 3) / 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             buf_en,
    input  logic             sync_mode,
    input  logic             rd_req,
    input  logic [CNT_W-1:0] count,
    output logic             rd_go,
    output rd_state_t        st
);
    rd_state_t st_nxt;
    logic [CNT_W-1:0] thr;

    assign thr = sync_mode ? CNT_W'(1) : CNT_W'(FILL_LVL);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RD_BYPASS;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            RD_BYPASS:  if (buf_en) st_nxt = RD_PREFILL;
            RD_PREFILL: begin
                if (!buf_en)           st_nxt = RD_BYPASS;
                else if (count >= thr) st_nxt = RD_STREAM;
            end
            RD_STREAM: begin
                if (!buf_en)            st_nxt = RD_BYPASS;
                else if (clr)           st_nxt = RD_PREFILL;
                else if (count == '0)   st_nxt = RD_PREFILL;
            end
            default: st_nxt = RD_BYPASS;
        endcase
    end

    always_comb begin
        rd_go = (st == RD_STREAM) && buf_en && !clr && rd_req && (count != '0);
    end
endmodule

// File: rtl/fbuf_wdog.sv
// No-output watchdog: prescaled tick counter, one-cycle registered fire.
module fbuf_wdog #(
    parameter int TICK_DIV = 64,
    parameter int WD_TICKS = 16,
    localparam int PRE_W   = $clog2(TICK_DIV),
    localparam int TK_W    = $clog2(WD_TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic activity,
    output logic fire
);
    logic [PRE_W-1:0] pre;
    logic [TK_W-1:0]  tk;
    logic tick, expire;

    assign tick   = (pre == PRE_W'(TICK_DIV - 1));
    assign expire = tick && (tk == TK_W'(WD_TICKS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || activity) begin
            pre  <= '0;
            tk   <= '0;
            fire <= 1'b0;
        end else begin
            pre  <= tick ? '0 : pre + PRE_W'(1);
            if (tick) tk <= expire ? '0 : tk + TK_W'(1);
            fire <= expire;
        end
    end
endmodule

// File: rtl/fbuf_ctrl.sv
// Prefilling frame buffer controller (top).
// Real deployment: CAP = 262144, BLK = 512, timeout sized for 40 s.
module fbuf_ctrl
    import fbuf_pkg::*;
#(
    parameter int CAP      = 256,
    parameter int BLK      = 16,
    parameter int TICK_DIV = 64,
    parameter int WD_TICKS = 16,
    localparam int AW      = $clog2(CAP),
    localparam int CNT_W   = AW + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       buf_en,
    input  logic       sync_mode,
    input  logic       wr_en,
    input  logic       wr_first,
    input  logic [7:0] wr_data,
    input  logic       rd_req,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic [6:0] fill_pct,
    output logic       overflow,
    output logic       flush_req
);
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count, free;
    logic             flush, wr_do, ovf_set, wr_commit, rd_go;
    logic             byp_q;
    logic [7:0]       byp_data, mem_q;
    rd_state_t        rd_st;

    assign flush     = flush_req || !buf_en;
    assign free      = CNT_W'(CAP) - count;
    assign wr_commit = wr_do && !flush;

    fbuf_wr_fsm #(.BLK(BLK), .CNT_W(CNT_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .wr_en(wr_en), .wr_first(wr_first), .free(free),
        .wr_do(wr_do), .ovf_set(ovf_set)
    );

    fbuf_rd_fsm #(.CAP(CAP), .CNT_W(CNT_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .clr(flush_req),
        .buf_en(buf_en), .sync_mode(sync_mode), .rd_req(rd_req),
        .count(count), .rd_go(rd_go), .st(rd_st)
    );

    fbuf_wdog #(.TICK_DIV(TICK_DIV), .WD_TICKS(WD_TICKS)) u_wd (
        .clk(clk), .rst_n(rst_n), .run(buf_en),
        .activity(rd_valid), .fire(flush_req)
    );

    fbuf_mem #(.DEPTH(CAP), .DW(8)) u_mem (
        .clk(clk), .we(wr_commit), .waddr(wr_ptr), .wdata(wr_data),
        .raddr(rd_ptr), .rdata(mem_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_commit) wr_ptr <= wr_ptr + AW'(1);
            if (rd_go)     rd_ptr <= rd_ptr + AW'(1);
            count <= count + CNT_W'(wr_commit) - CNT_W'(rd_go);
            if (ovf_set) overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            byp_q    <= 1'b0;
            byp_data <= '0;
        end else begin
            byp_q    <= !buf_en;
            byp_data <= wr_data;
            rd_valid <= buf_en ? rd_go : wr_en;
        end
    end

    assign rd_data  = byp_q ? byp_data : mem_q;
    assign fill_pct = 7'((32'(count) * 32'd100) / 32'(CAP));
endmodule

// File: rtl/fbuf_ctrl_chk.sv
module fbuf_ctrl_chk
    import fbuf_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             buf_en,
    input logic             sync_mode,
    input logic             wr_en,
    input logic             rd_valid,
    input logic [6:0]       fill_pct,
    input logic             overflow,
    input logic             flush_req,
    input logic [CNT_W-1:0] count,
    input logic             rd_go,
    input rd_state_t        rd_st
);
    // R7
    fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_pct <= 7'd100);

    // R2
    prefill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && !sync_mode && rd_st == RD_PREFILL) |-> !rd_go);

    // R3
    no_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> (count != '0));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (count == '0 && !overflow));

    // R10
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !flush_req);

    // R5
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && buf_en && !flush_req) |=> overflow);

    // R9
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en && $past(!buf_en)) |-> (rd_valid == $past(wr_en)));
endmodule

bind fbuf_ctrl fbuf_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .sync_mode(sync_mode),
    .wr_en(wr_en), .rd_valid(rd_valid), .fill_pct(fill_pct),
    .overflow(overflow), .flush_req(flush_req), .count(count),
    .rd_go(rd_go), .rd_st(rd_st)
);

// File: tb/fbuf_ctrl_bench.sv
`timescale 1ns/1ps
module fbuf_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       buf_en = 1'b0, sync_mode = 1'b0;
    logic       wr_en = 1'b0, wr_first = 1'b0, rd_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_valid, overflow, flush_req;
    logic [7:0] rd_data;
    logic [6:0] fill_pct;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fbuf_ctrl u_fbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .sync_mode(sync_mode),
        .wr_en(wr_en), .wr_first(wr_first), .wr_data(wr_data),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .fill_pct(fill_pct), .overflow(overflow), .flush_req(flush_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic en, input logic sm);
        @(negedge clk);
        rst_n = 1'b0; buf_en = en; sync_mode = sm;
        wr_en = 0; wr_first = 0; rd_req = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_block(input int base);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_first = (i == 0); wr_data = 8'(base + i);
        end
        @(negedge clk);
        wr_en = 1'b0; wr_first = 1'b0;
    endtask

    // Holds rd_req for n cycles, compares each returned byte to the running
    // expected value, and returns how many bytes came out.
    task automatic rd_burst(input string req, input int n, inout int nxt, output int got);
        got = 0;
        rd_req = 1'b1;
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i == n - 1) rd_req = 1'b0;
            if (rd_valid) begin
                check(req, int'(rd_data), nxt & 255);
                nxt++;
                got++;
            end
        end
        rd_req = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(1'b1, 1'b0);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 overflow", int'(overflow), 0);
        check("R1 flush_req", int'(flush_req), 0);
        check("R1 fill_pct", int'(fill_pct), 0);
    endtask

    task automatic t_prefill;
        int nxt, got;
        do_reset(1'b1, 1'b0);
        for (int b = 0; b < 11; b++) wr_block(b * 16);
        check("R7 fill at 176", int'(fill_pct), 68);
        nxt = 0;
        rd_burst("R2 data", 20, nxt, got);
        check("R2 no output below level", got, 0);
        wr_block(176);
        check("R7 fill at 192", int'(fill_pct), 75);
        nxt = 0;
        rd_burst("R4 order", 200, nxt, got);
        check("R3 drained count", got, 192);
        check("R3 fill after drain", int'(fill_pct), 0);
        wr_block(192);
        rd_burst("R3 data", 10, nxt, got);
        check("R3 prefill re-armed", got, 0);
    endtask

    task automatic t_overflow;
        int nxt, got;
        do_reset(1'b1, 1'b0);
        for (int b = 0; b < 15; b++) wr_block(b * 16);
        check("R5 no overflow at 240", int'(overflow), 0);
        wr_block(240);
        check("R5 boundary block admitted", int'(fill_pct), 100);
        check("R5 no overflow at boundary", int'(overflow), 0);
        wr_block(8'hA0);
        check("R5 overflow set", int'(overflow), 1);
        check("R5 fill unchanged", int'(fill_pct), 100);
        nxt = 0;
        rd_burst("R5 stored data intact", 270, nxt, got);
        check("R5 byte total", got, 256);
        check("R5 overflow sticky", int'(overflow), 1);
    endtask

    task automatic t_stray;
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_first = 1'b0; wr_data = 8'(i);
        end
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 stray bytes ignored", int'(fill_pct), 0);
        wr_block(0);
        check("R7 one block", int'(fill_pct), 6);
    endtask

    task automatic t_sync;
        int nxt, got;
        do_reset(1'b1, 1'b1);
        wr_block(8'h30);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check("R8 served below level", int'(rd_valid), 1);
        check("R4 one-cycle latency data", int'(rd_data), 8'h30);
        nxt = 8'h31;
        rd_burst("R8 data", 20, nxt, got);
        check("R8 rest of block", got, 15);
    endtask

    task automatic t_bypass;
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h5A;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 valid follows", int'(rd_valid), 1);
        check("R9 data follows", int'(rd_data), 8'h5A);
        @(negedge clk);
        check("R9 valid drops", int'(rd_valid), 0);
        wr_block(0);
        check("R9 nothing stored", int'(fill_pct), 0);
    endtask

    task automatic t_watchdog;
        int start, fired_at;
        do_reset(1'b1, 1'b0);
        start = cyc;
        fired_at = -1;
        wr_block(0);
        wr_block(16);
        check("R10 filled before timeout", int'(fill_pct), 12);
        for (int i = 0; i < 1200 && fired_at < 0; i++) begin
            @(negedge clk);
            if (flush_req) fired_at = cyc - start;
        end
        check("R10 fired in window", int'(fired_at >= 1000 && fired_at <= 1060), 1);
        @(negedge clk);
        check("R10 pulse one cycle", int'(flush_req), 0);
        check("R10 buffer emptied", int'(fill_pct), 0);
        wr_block(0);
        check("R10 refills after flush", int'(fill_pct), 6);
    endtask

    initial begin
        t_reset();
        t_prefill();
        t_overflow();
        t_stray();
        t_sync();
        t_bypass();
        t_watchdog();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule